// File: doc/BRIEF.md
# Prioritised region permission checker

This block decides whether a memory access may proceed given a set of address regions. An access comes in as a byte address, a byte count, a requested permission mask (read, write, execute) and a flag saying whether it comes from machine mode or from a lower mode. Alongside it the block sees every region's decoded inclusive bounds and its configuration field, plus two security flags: a lockdown flag that switches permissions to a pair of fixed truth tables, and a whitelist flag that makes unmatched accesses fail even in machine mode.

Regions are scanned from index 0 upward. The first region that touches the access decides the result. If the access lies only partly inside that region, it is refused outright. If it lies fully inside an active region, that region supplies the allowed mask. When no region decides, a small set of default rules applies. The verdict and the allowed mask are registered, and they appear one clock after the request strobe.

Top module: `pmp_perm_check`

## Requirements
- R1: The first and last byte (last = address + size − 1) are tested against every region in index order. The first region that contains exactly one of the two bytes ends the search with deny and allowed mask 0. This holds whatever that region's mode field is.
- R2: The lowest-indexed region that contains both bytes and has a nonzero mode field (cfg[4:3] != 0) decides the result, and no later region is consulted. A region with mode field 0 that contains both bytes is skipped.
- R3: With lockdown clear, a deciding region allows RWX to an unlocked (cfg[5]=0) machine-mode access. Otherwise, for a lower mode or a locked region, it allows the region's own bits: cfg[0]=R, cfg[1]=W, cfg[2]=X. Mask encoding everywhere: bit0 R, bit1 W, bit2 X.
- R4: With lockdown set, machine mode uses the table index {L,R,W,X} (L is the MSB). Indices 0,1,4,5,6,7,8 give none; 2,3,14 give RW; 9,10 give X; 11,13 give RX; 12,15 give R.
- R5: With lockdown set, a lower mode uses the same index. Indices 0,8,9,12,13,14 give none; 1,10,11 give X; 2,4,15 give R; 3,6 give RW; 5 gives RX; 7 gives RWX.
- R6: When a region decides, the access is granted exactly when every requested bit is present in the allowed mask.
- R7: When no region decides and the whitelist flag is set, the access is denied with mask 0.
- R8: When no region decides, the whitelist flag is clear and lockdown is set, a machine-mode request without X is granted with mask RW. Any other request on this path is denied with mask 0.
- R9: When no region decides and both flags are clear, machine mode is granted with mask RWX, and a lower mode is denied with mask 0.
- R10: A size of 0 means WORD_BYTES bytes (default 4).
- R11: Reset clears rsp_valid, rsp_grant and rsp_allowed. A request sampled with req_valid high produces its result with rsp_valid high on the next clock. After a cycle with req_valid low, rsp_valid is low and rsp_grant and rsp_allowed keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | First byte address |
| req_size | input | SIZE_W | Byte count, 0 means WORD_BYTES |
| req_perm | input | 3 | Requested mask {X,W,R} |
| req_mmode | input | 1 | 1 = machine mode, 0 = lower mode |
| sec_lockdown | input | 1 | Lockdown truth-table mode |
| sec_whitelist | input | 1 | Deny unmatched accesses in every mode |
| rgn_lo | input | N_REGIONS*ADDR_W | Inclusive lower bound per region, region i at slice i |
| rgn_hi | input | N_REGIONS*ADDR_W | Inclusive upper bound per region |
| rgn_cfg | input | N_REGIONS*6 | Per region {L, mode[1:0], X, W, R} |
| rsp_valid | output | 1 | Result valid |
| rsp_grant | output | 1 | 1 = access allowed |
| rsp_allowed | output | 3 | Allowed mask {X,W,R} |

## Verification
The bench aims at accesses that straddle a region edge, including one produced by a size of 0. A checker that tested only the first byte would grant these when it should deny. It places a restrictive low-index region inside a permissive higher one: a design that scanned in the wrong order, or that merged the regions, would grant a write it should refuse. It also makes the low region inactive to confirm the fall-through. The bench sweeps all sixteen lockdown table indices in both modes, where a single swapped entry shows up as a wrong mask. It also drives every default path: a confusion between the whitelist flag and lockdown, or the execute exemption applied to the wrong mode, shows up as a wrong grant.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
    typedef logic [2:0] perm_t;

    localparam perm_t PERM_NONE = 3'b000;
    localparam perm_t PERM_R    = 3'b001;
    localparam perm_t PERM_RW   = 3'b011;
    localparam perm_t PERM_X    = 3'b100;
    localparam perm_t PERM_RX   = 3'b101;
    localparam perm_t PERM_RWX  = 3'b111;

    localparam int CFG_W = 6;

    typedef struct packed {
        logic  valid;
        logic  grant;
        perm_t allowed;
    } rsp_t;
endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [ADDR_W-1:0] first_byte,
    input  logic [ADDR_W-1:0] last_byte,
    output logic              first_in,
    output logic              last_in
);
    always_comb begin
        first_in = (first_byte >= lo) && (first_byte <= hi);
        last_in  = (last_byte  >= lo) && (last_byte  <= hi);
    end
endmodule

// File: rtl/pmp_lockdown_table.sv
module pmp_lockdown_table
    import pmp_chk_pkg::*;
(
    input  logic [3:0] idx,
    input  logic       mmode,
    output perm_t      perm
);
    always_comb begin
        perm = PERM_NONE;
        if (mmode) begin
            case (idx)
                4'd2, 4'd3, 4'd14: perm = PERM_RW;
                4'd9, 4'd10:       perm = PERM_X;
                4'd11, 4'd13:      perm = PERM_RX;
                4'd12, 4'd15:      perm = PERM_R;
                default:           perm = PERM_NONE;
            endcase
        end else begin
            case (idx)
                4'd1, 4'd10, 4'd11: perm = PERM_X;
                4'd2, 4'd4, 4'd15:  perm = PERM_R;
                4'd3, 4'd6:         perm = PERM_RW;
                4'd5:               perm = PERM_RX;
                4'd7:               perm = PERM_RWX;
                default:            perm = PERM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
    import pmp_chk_pkg::*;
#(
    parameter int N_REGIONS  = 4,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [SIZE_W-1:0]             req_size,
    input  logic [2:0]                    req_perm,
    input  logic                          req_mmode,
    input  logic                          sec_lockdown,
    input  logic                          sec_whitelist,
    input  logic [N_REGIONS*ADDR_W-1:0]   rgn_lo,
    input  logic [N_REGIONS*ADDR_W-1:0]   rgn_hi,
    input  logic [N_REGIONS*CFG_W-1:0]    rgn_cfg,
    output logic                          rsp_valid,
    output logic                          rsp_grant,
    output logic [2:0]                    rsp_allowed
);
    localparam logic [ADDR_W-1:0] WORD_SIZE = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] eff_size;
    logic [ADDR_W-1:0] last_byte;
    logic [N_REGIONS-1:0] hit_first;
    logic [N_REGIONS-1:0] hit_last;
    logic [N_REGIONS-1:0] active;
    perm_t                region_allow [N_REGIONS];

    rsp_t state_d, state_q;

    always_comb begin
        eff_size  = (req_size == '0) ? WORD_SIZE : ADDR_W'(req_size);
        last_byte = req_addr + eff_size - ADDR_W'(1);
    end

    for (genvar i = 0; i < N_REGIONS; i++) begin : g_region
        logic [CFG_W-1:0] cfg;
        perm_t            lock_perm;
        perm_t            plain_perm;

        assign cfg = rgn_cfg[i*CFG_W +: CFG_W];

        pmp_region_match #(.ADDR_W(ADDR_W)) u_match (
            .lo         (rgn_lo[i*ADDR_W +: ADDR_W]),
            .hi         (rgn_hi[i*ADDR_W +: ADDR_W]),
            .first_byte (req_addr),
            .last_byte  (last_byte),
            .first_in   (hit_first[i]),
            .last_in    (hit_last[i])
        );

        pmp_lockdown_table u_table (
            .idx   ({cfg[5], cfg[0], cfg[1], cfg[2]}),
            .mmode (req_mmode),
            .perm  (lock_perm)
        );

        always_comb begin
            plain_perm      = (req_mmode && !cfg[5]) ? PERM_RWX : cfg[2:0];
            region_allow[i] = sec_lockdown ? lock_perm : plain_perm;
            active[i]       = (cfg[4:3] != 2'b00);
        end
    end

    always_comb begin
        logic  decided;
        logic  grant;
        perm_t allowed;

        decided = 1'b0;
        grant   = 1'b0;
        allowed = PERM_NONE;

        for (int i = 0; i < N_REGIONS; i++) begin
            if (!decided) begin
                if (hit_first[i] != hit_last[i]) begin
                    decided = 1'b1;
                    grant   = 1'b0;
                    allowed = PERM_NONE;
                end else if (hit_first[i] && active[i]) begin
                    decided = 1'b1;
                    allowed = region_allow[i];
                    grant   = ((req_perm & allowed) == req_perm);
                end
            end
        end

        if (!decided) begin
            if (sec_whitelist) begin
                grant   = 1'b0;
                allowed = PERM_NONE;
            end else if (sec_lockdown) begin
                grant   = req_mmode && !req_perm[2];
                allowed = grant ? PERM_RW : PERM_NONE;
            end else begin
                grant   = req_mmode;
                allowed = req_mmode ? PERM_RWX : PERM_NONE;
            end
        end

        state_d       = state_q;
        state_d.valid = req_valid;
        if (req_valid) begin
            state_d.grant   = grant;
            state_d.allowed = allowed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid   = state_q.valid;
    assign rsp_grant   = state_q.grant;
    assign rsp_allowed = state_q.allowed;
endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 4,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SIZE_W-1:0] req_size,
    input logic [2:0]        req_perm,
    input logic              sec_lockdown,
    input logic [ADDR_W-1:0] r0_lo,
    input logic [ADDR_W-1:0] r0_hi,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [2:0]        rsp_allowed
);
    logic [ADDR_W-1:0] tail;
    logic              r0_split;

    always_comb begin
        tail     = req_addr + ((req_size == '0) ? ADDR_W'(WORD_BYTES) : ADDR_W'(req_size)) - ADDR_W'(1);
        r0_split = ((req_addr >= r0_lo) && (req_addr <= r0_hi)) != ((tail >= r0_lo) && (tail <= r0_hi));
    end

    // R11
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_grant) && $stable(rsp_allowed)));
    // R1
    a_r1_region0_split_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && r0_split) |=> (!rsp_grant && rsp_allowed == 3'b000));
    // R6
    a_r6_grant_covers_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_grant || ((rsp_allowed & $past(req_perm)) == $past(req_perm))));
    // R4 / R5: no table row or lockdown default yields write without read
    a_r5_no_write_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_lockdown) |=> !(rsp_allowed[1] && !rsp_allowed[0]));
endmodule

bind pmp_perm_check pmp_perm_check_sva #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .WORD_BYTES (WORD_BYTES)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_perm     (req_perm),
    .sec_lockdown (sec_lockdown),
    .r0_lo        (rgn_lo[ADDR_W-1:0]),
    .r0_hi        (rgn_hi[ADDR_W-1:0]),
    .rsp_valid    (rsp_valid),
    .rsp_grant    (rsp_grant),
    .rsp_allowed  (rsp_allowed)
);

// File: tb/pmp_perm_check_test.sv
module pmp_perm_check_test;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [2:0]    req_perm = '0;
    logic          req_mmode = 1'b0;
    logic          sec_lockdown = 1'b0;
    logic          sec_whitelist = 1'b0;
    logic [N*AW-1:0] rgn_lo, rgn_hi;
    logic [N*6-1:0]  rgn_cfg;
    logic          rsp_valid, rsp_grant;
    logic [2:0]    rsp_allowed;

    logic [AW-1:0] lo_a [N];
    logic [AW-1:0] hi_a [N];
    logic [5:0]    cfg_a [N];

    int checks = 0;
    int errors = 0;
    logic          exp_grant = 1'b0;
    logic [2:0]    exp_allowed = 3'b000;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rgn_lo[i*AW +: AW] = lo_a[i];
            rgn_hi[i*AW +: AW] = hi_a[i];
            rgn_cfg[i*6 +: 6]  = cfg_a[i];
        end
    end

    pmp_perm_check #(.N_REGIONS(N), .ADDR_W(AW), .SIZE_W(SW), .WORD_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
        .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist),
        .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_cfg(rgn_cfg),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_allowed(rsp_allowed));

    // allowed masks encoded R=1, W=2, X=4, indexed by {L,R,W,X}
    int m_tab [16] = '{0, 0, 3, 3, 0, 0, 0, 0, 0, 4, 4, 5, 1, 5, 3, 1};
    int u_tab [16] = '{0, 4, 1, 3, 1, 5, 3, 7, 0, 0, 4, 4, 0, 0, 0, 1};

    task automatic model(input logic [AW-1:0] a, input logic [SW-1:0] s,
                         input logic [2:0] p, input logic mm,
                         output logic g, output logic [2:0] al);
        logic [AW-1:0] last;
        bit in_f, in_l, done;
        int idx;
        last = a + ((s == 0) ? 32'd4 : 32'(s)) - 32'd1;
        done = 0; g = 0; al = 0;
        for (int i = 0; i < N && !done; i++) begin
            in_f = (a >= lo_a[i]) && (a <= hi_a[i]);
            in_l = (last >= lo_a[i]) && (last <= hi_a[i]);
            if (in_f ^ in_l) begin
                done = 1; g = 0; al = 0;
            end else if (in_f && cfg_a[i][4:3] != 0) begin
                done = 1;
                if (sec_lockdown) begin
                    idx = cfg_a[i][5]*8 + cfg_a[i][0]*4 + cfg_a[i][1]*2 + cfg_a[i][2];
                    al = mm ? 3'(m_tab[idx]) : 3'(u_tab[idx]);
                end else if (mm && !cfg_a[i][5]) al = 3'b111;
                else al = cfg_a[i][2:0];
                g = ((p & al) == p);
            end
        end
        if (!done) begin
            if (sec_whitelist) begin g = 0; al = 0; end
            else if (sec_lockdown) begin
                if (mm && !p[2]) begin g = 1; al = 3'b011; end
                else begin g = 0; al = 0; end
            end else if (mm) begin g = 1; al = 3'b111; end
            else begin g = 0; al = 0; end
        end
    endtask

    task automatic check3(input string tag, input logic v, input logic g, input logic [2:0] al);
        checks++;
        if (rsp_valid !== v || rsp_grant !== g || rsp_allowed !== al) begin
            errors++;
            $display("FAIL %s: got valid=%0b grant=%0b allowed=%03b, expected valid=%0b grant=%0b allowed=%03b",
                     tag, rsp_valid, rsp_grant, rsp_allowed, v, g, al);
        end
    endtask

    task automatic issue(input string tag, input logic [AW-1:0] a, input logic [SW-1:0] s,
                         input logic [2:0] p, input logic mm);
        @(negedge clk);
        check3("R11 idle hold", 1'b0, exp_grant, exp_allowed);
        req_valid = 1; req_addr = a; req_size = s; req_perm = p; req_mmode = mm;
        model(a, s, p, mm, exp_grant, exp_allowed);
        @(negedge clk);
        check3(tag, 1'b1, exp_grant, exp_allowed);
        req_valid = 0;
    endtask

    task automatic clear_regions();
        for (int i = 0; i < N; i++) begin
            lo_a[i] = 0; hi_a[i] = 0; cfg_a[i] = 0;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_regions();
        repeat (3) @(negedge clk);
        check3("R11 reset state", 1'b0, 1'b0, 3'b000);
        rst_n = 1;

        // R9 defaults
        issue("R9 machine default", 32'h40, 0, 3'b111, 1);
        issue("R9 lower default", 32'h40, 0, 3'b001, 0);
        // R7 whitelist
        sec_whitelist = 1;
        issue("R7 whitelist machine", 32'h40, 0, 3'b001, 1);
        sec_lockdown = 1;
        issue("R7 whitelist over lockdown", 32'h40, 0, 3'b001, 1);
        sec_whitelist = 0;
        // R8 lockdown defaults
        issue("R8 machine read", 32'h40, 0, 3'b011, 1);
        issue("R8 machine exec", 32'h40, 0, 3'b100, 1);
        issue("R8 lower read", 32'h40, 0, 3'b001, 0);
        sec_lockdown = 0;

        // R3 plain permissions
        lo_a[0] = 32'h1000; hi_a[0] = 32'h1FFF; cfg_a[0] = 6'b0_01_001;
        issue("R3 machine unlocked", 32'h1100, 4, 3'b010, 1);
        issue("R3 lower read", 32'h1100, 4, 3'b001, 0);
        issue("R6 lower write refused", 32'h1100, 4, 3'b011, 0);
        cfg_a[0] = 6'b1_01_001;
        issue("R3 machine locked", 32'h1100, 4, 3'b010, 1);

        // R1 partial overlap
        issue("R1 straddle top", 32'h1FFE, 4, 3'b001, 1);
        issue("R1 straddle bottom", 32'h0FFE, 4, 3'b001, 1);
        cfg_a[0] = 6'b0_00_111;
        issue("R1 straddle inactive region", 32'h1FFE, 4, 3'b001, 1);

        // R2 priority
        cfg_a[0] = 6'b0_11_001;
        lo_a[1] = 32'h0; hi_a[1] = 32'hFFFF; cfg_a[1] = 6'b0_11_111;
        issue("R2 low index wins", 32'h1100, 4, 3'b010, 0);
        issue("R2 outside low region", 32'h3000, 4, 3'b010, 0);
        cfg_a[0] = 6'b0_00_001;
        issue("R2 inactive skipped", 32'h1100, 4, 3'b010, 0);
        cfg_a[0] = 6'b0_11_001;

        // R10 size zero
        issue("R10 size0 fits", 32'h1FFC, 0, 3'b001, 0);
        issue("R10 size0 straddles", 32'h1FFE, 0, 3'b001, 0);
        issue("R10 size1 last byte", 32'h1FFF, 1, 3'b001, 0);

        // R4 / R5 tables
        sec_lockdown = 1;
        for (int k = 0; k < 16; k++) begin
            cfg_a[0] = {k[3], 2'b10, k[0], k[1], k[2]};
            issue("R4 machine table", 32'h1200, 4, 3'b000, 1);
            issue("R5 lower table", 32'h1200, 4, 3'b000, 0);
            issue("R6 lockdown read", 32'h1200, 4, 3'b001, k[0]);
        end
        sec_lockdown = 0;

        // random mix
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < N; i++) begin
                lo_a[i] = 32'($urandom_range(0, 255)) << 4;
                hi_a[i] = lo_a[i] + 32'($urandom_range(0, 96));
                cfg_a[i] = 6'($urandom);
            end
            sec_lockdown = 1'($urandom);
            sec_whitelist = ($urandom_range(0, 3) == 0);
            issue("R6 random", 32'($urandom_range(0, 4200)), 4'($urandom), 3'($urandom), 1'($urandom));
        end

        @(negedge clk);
        check3("R11 final idle", 1'b0, exp_grant, exp_allowed);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule